// File: doc/BRIEF.md
# Comparator Event Detector with Debounce

This block watches the one-bit result of an analog comparator and raises a sticky event flag when a condition chosen by software occurs. The result is 1 when the comparator's positive input is above its negative input, and 0 otherwise. The block takes one sample of that bit per machine cycle, on a sample strobe. Software picks one of eight conditions with a 3-bit mode field: a level (low or high), an edge (rising, falling or any toggle), or a debounced edge.

The debounced modes are for slow or noisy inputs. A relevant transition arms a resample that waits until a free-running external timer has sent two overflow pulses. The flag is then set only if the next sample still shows the level that the transition led to, so it rises between one and two timer periods after the edge.

The block works only while the enable bit is set and the low-power indication is clear. An interrupt request is the event flag gated by an interrupt-enable input.

Top module: `cmp_event_det`

## Requirements
- R1: The sampled bit is 1 when the positive input is above the negative input. Mode 000 sets the flag on a sample of 0, and mode 100 sets it on a sample of 1.
- R2: While en_i is 0, no sample sets the flag.
- R3: The comparator bit is taken only in a cycle where sample_i is 1, and a resulting flag set shows on flag_o after the next clock edge.
- R4: The flag stays 1 until flag_clr_i clears it. The hardware never clears it. When a set and a clear fall in the same cycle, the set wins.
- R5: While low_pwr_i is 1, the block acts as disabled and no sample sets the flag.
- R6: Edge modes compare each sample with the one before it: mode 001 detects a rise 0 to 1, mode 011 a fall 1 to 0, and mode 010 either change.
- R7: Mode 110 (debounced rise), 101 (debounced fall) and 111 (debounced toggle) arm a wait on a relevant transition. After two tmr_ovf_i pulses, the next sample sets the flag if it equals the level the transition led to.
- R8: In a debounced mode, if the resample differs from the expected level, the event is discarded and the flag is not set.
- R9: Transitions during a debounce wait are ignored. Disabling the block cancels the wait and clears the overflow count.
- R10: The first sample after the block becomes active only loads the previous-sample register, so it never counts as an edge.
- R11: irq_o is 1 exactly when flag_o is 1 and irq_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator result bit |
| sample_i | input | 1 | Once-per-machine-cycle sample strobe |
| tmr_ovf_i | input | 1 | Free-running timer overflow pulse |
| en_i | input | 1 | Block enable |
| mode_i | input | 3 | Event condition select |
| low_pwr_i | input | 1 | Idle or power-down indication, forces disable |
| flag_clr_i | input | 1 | Software clear of the event flag |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Level and edge events set flag_o at the first clock edge after the strobe cycle. A debounced event sets it at the edge after the resample strobe that follows the second overflow pulse. irq_o follows flag_o and irq_en_i in the same cycle with no register between them. The bench drives every input on a falling edge and holds a strobe, clear or overflow for one full cycle. It reads the outputs on the falling edge after that cycle, which is half a period after the edge where they are due to change. Before each debounced resample, it also checks that the flag is still clear.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  typedef enum logic [2:0] {
    MODE_LOW       = 3'b000,
    MODE_RISE      = 3'b001,
    MODE_TOGGLE    = 3'b010,
    MODE_FALL      = 3'b011,
    MODE_HIGH      = 3'b100,
    MODE_DB_FALL   = 3'b101,
    MODE_DB_RISE   = 3'b110,
    MODE_DB_TOGGLE = 3'b111
  } cmp_mode_e;

  function automatic logic is_debounced(cmp_mode_e m);
    return m[2] & (m[1] | m[0]);
  endfunction

endpackage

// File: rtl/cmp_sampler.sv
module cmp_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic strobe_i,
  input  logic cmp_i,
  output logic smp_o,
  output logic prev_o,
  output logic primed_o
);

  logic prev_q, primed_q;

  assign smp_o    = strobe_i & active_i;
  assign prev_o   = prev_q;
  assign primed_o = primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else if (!active_i) begin
      primed_q <= 1'b0;
    end else if (strobe_i) begin
      prev_q   <= cmp_i;
      primed_q <= 1'b1;
    end
  end

  // R10: the history is rebuilt each time the block becomes active
  assert_prime_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !primed_q);

endmodule

// File: rtl/cmp_cond_decode.sv
module cmp_cond_decode
  import cmp_evt_pkg::*;
(
  input  cmp_mode_e mode_i,
  input  logic      smp_i,
  input  logic      primed_i,
  input  logic      prev_i,
  input  logic      cur_i,
  output logic      direct_hit_o,
  output logic      arm_o
);

  logic rise, fall;

  assign rise = smp_i & primed_i & ~prev_i & cur_i;
  assign fall = smp_i & primed_i & prev_i & ~cur_i;

  always_comb begin
    direct_hit_o = 1'b0;
    arm_o        = 1'b0;
    unique case (mode_i)
      MODE_LOW:       direct_hit_o = smp_i & ~cur_i;
      MODE_HIGH:      direct_hit_o = smp_i & cur_i;
      MODE_RISE:      direct_hit_o = rise;
      MODE_FALL:      direct_hit_o = fall;
      MODE_TOGGLE:    direct_hit_o = rise | fall;
      MODE_DB_RISE:   arm_o        = rise;
      MODE_DB_FALL:   arm_o        = fall;
      MODE_DB_TOGGLE: arm_o        = rise | fall;
      default: ;
    endcase
  end

endmodule

// File: rtl/cmp_debounce.sv
module cmp_debounce #(
  parameter int OVF_WAIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic dbm_i,
  input  logic arm_i,
  input  logic smp_i,
  input  logic cur_i,
  input  logic ovf_i,
  output logic hit_o
);

  localparam int CNT_W = $clog2(OVF_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(OVF_WAIT);

  logic             busy_q, exp_q, done;
  logic [CNT_W-1:0] cnt_q;

  assign done  = busy_q & (cnt_q == CNT_DONE);
  assign hit_o = done & dbm_i & smp_i & (cur_i == exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      exp_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!active_i || !dbm_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (arm_i) begin
        busy_q <= 1'b1;
        exp_q  <= cur_i;
        cnt_q  <= '0;
      end
    end else if (done) begin
      // resample slot: leave the wait on the next strobe, hit or not
      if (smp_i) busy_q <= 1'b0;
    end else if (ovf_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_DONE);

  assert_abort_on_disable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !active_i) |=> (!busy_q && cnt_q == '0));

  assert_no_early_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != CNT_DONE) |-> !hit_o);

endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

endmodule

// File: rtl/cmp_event_det.sv
module cmp_event_det
  import cmp_evt_pkg::*;
#(
  parameter int OVF_WAIT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmp_i,
  input  logic       sample_i,
  input  logic       tmr_ovf_i,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  input  logic       low_pwr_i,
  input  logic       flag_clr_i,
  input  logic       irq_en_i,
  output logic       flag_o,
  output logic       irq_o
);

  cmp_mode_e mode;
  logic active, smp, prev, primed, direct_hit, arm, db_hit, evt_set;

  assign mode   = cmp_mode_e'(mode_i);
  assign active = en_i & ~low_pwr_i;

  cmp_sampler u_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .strobe_i (sample_i),
    .cmp_i    (cmp_i),
    .smp_o    (smp),
    .prev_o   (prev),
    .primed_o (primed)
  );

  cmp_cond_decode u_decode (
    .mode_i       (mode),
    .smp_i        (smp),
    .primed_i     (primed),
    .prev_i       (prev),
    .cur_i        (cmp_i),
    .direct_hit_o (direct_hit),
    .arm_o        (arm)
  );

  cmp_debounce #(.OVF_WAIT(OVF_WAIT)) u_debounce (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .dbm_i    (is_debounced(mode)),
    .arm_i    (arm),
    .smp_i    (smp),
    .cur_i    (cmp_i),
    .ovf_i    (tmr_ovf_i),
    .hit_o    (db_hit)
  );

  assign evt_set = direct_hit | db_hit;

  cmp_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_set),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );

  // R2 R5: nothing is detected while inactive
  assert_idle_no_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !evt_set);

  assert_rise_after_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(sample_i && active));

endmodule

// File: tb/cmp_event_det_tb_top.sv
module cmp_event_det_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp = 1'b0, sample = 1'b0, ovf = 1'b0, en = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       lp = 1'b0, clr = 1'b0, irq_en = 1'b0;
  logic       flag, irq;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  cmp_event_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .sample_i(sample),
    .tmr_ovf_i(ovf), .en_i(en), .mode_i(mode), .low_pwr_i(lp),
    .flag_clr_i(clr), .irq_en_i(irq_en), .flag_o(flag), .irq_o(irq)
  );

  // {clear first, mode, cmp bit, expected flag}
  localparam logic [5:0] VEC [16] = '{
    6'b1_001_0_0, 6'b1_001_1_1, 6'b1_001_1_0, 6'b1_001_0_0,
    6'b1_011_0_0, 6'b1_011_1_0, 6'b1_011_0_1, 6'b1_010_1_1,
    6'b1_010_1_0, 6'b1_010_0_1, 6'b1_000_0_1, 6'b1_100_0_0,
    6'b1_100_1_1, 6'b1_000_1_0, 6'b1_100_1_1, 6'b0_000_1_1
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic c);
    @(negedge clk); cmp = c; sample = 1'b1;
    @(negedge clk); sample = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic overflow();
    @(negedge clk); ovf = 1'b1;
    @(negedge clk); ovf = 1'b0;
  endtask

  task automatic reenable();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(flag, 1'b0, "R4 reset flag");
    chk(irq, 1'b0, "R11 reset irq");
    rst_n = 1'b1;
    @(negedge clk); en = 1'b1;

    // R1 R6 R10 table walk
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][5]) clear_flag();
      mode = VEC[i][4:2];
      strobe(VEC[i][1]);
      chk(flag, VEC[i][0], $sformatf("R1 R6 table row %0d", i));
    end

    // R11 irq gating
    irq_en = 1'b1; #1;
    chk(irq, 1'b1, "R11 irq with flag");
    irq_en = 1'b0; #1;
    chk(irq, 1'b0, "R11 irq masked");

    // R3 no sample without strobe
    clear_flag(); mode = 3'b100;
    @(negedge clk); cmp = 1'b1;
    repeat (4) @(negedge clk);
    chk(flag, 1'b0, "R3 no strobe");
    strobe(1'b1);
    chk(flag, 1'b1, "R3 strobe sets");

    // R4 set wins over clear in the same cycle
    @(negedge clk); clr = 1'b1; sample = 1'b1;
    @(negedge clk); clr = 1'b0; sample = 1'b0;
    chk(flag, 1'b1, "R4 set beats clear");
    clear_flag();
    chk(flag, 1'b0, "R4 software clear");

    // R2 disabled
    @(negedge clk); en = 1'b0;
    strobe(1'b1);
    chk(flag, 1'b0, "R2 disabled no set");
    // R5 low power overrides enable
    @(negedge clk); en = 1'b1; lp = 1'b1;
    strobe(1'b1);
    chk(flag, 1'b0, "R5 low power no set");
    @(negedge clk); lp = 1'b0;

    // R10 no false edge after enabling
    mode = 3'b001;
    strobe(1'b0);
    reenable();
    strobe(1'b1);
    chk(flag, 1'b0, "R10 first sample primes only");

    // R7 debounced rise
    mode = 3'b110;
    strobe(1'b0);
    strobe(1'b1);
    chk(flag, 1'b0, "R7 armed not set");
    overflow();
    strobe(1'b1);
    chk(flag, 1'b0, "R7 one overflow only");
    overflow();
    chk(flag, 1'b0, "R7 before resample");
    strobe(1'b1);
    chk(flag, 1'b1, "R7 debounced rise");

    // R8 mismatch discarded
    clear_flag();
    strobe(1'b0);
    strobe(1'b1);
    overflow(); overflow();
    strobe(1'b0);
    chk(flag, 1'b0, "R8 mismatch discarded");

    // R9 transitions during wait ignored
    reenable(); mode = 3'b101;
    strobe(1'b1);
    strobe(1'b0);
    strobe(1'b1);
    strobe(1'b0);
    chk(flag, 1'b0, "R9 wait ignores edges");
    overflow(); overflow();
    strobe(1'b0);
    chk(flag, 1'b1, "R9 original wait completes");

    // R9 disable aborts the wait
    clear_flag();
    strobe(1'b1);
    strobe(1'b0);
    reenable();
    strobe(1'b0);
    overflow(); overflow();
    strobe(1'b0);
    chk(flag, 1'b0, "R9 abort on disable");

    // R7 debounced toggle
    mode = 3'b111;
    strobe(1'b0);
    strobe(1'b1);
    overflow(); overflow();
    strobe(1'b1);
    chk(flag, 1'b1, "R7 debounced toggle");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule